// File: doc/BRIEF.md
# Indexed Chipset Configuration Registers

This block holds the configuration registers of a PC-style chipset behind an index/data pair of I/O ports. Software first writes a register number to the index port, then reads or writes the data port to reach that register. Only a fixed set of register numbers accepts writes. A few register numbers are read-only constants. Two register numbers return live status bits in place of part of their stored contents.

The block also decodes a system control port. Bit 1 of that port drives the fast A20 gate. A rising edge on bit 0 issues a single-cycle soft reset request to the CPU. The stored values of the writable registers leave the block on a flat bus, together with the selected CPU wait-state count, so that other chipset logic can decode them.

The I/O interface is a simple strobed byte bus with an 8-bit port address. Reads are combinational: the read data is valid while the read strobe and the address are held. Writes take effect at the next rising clock edge.

Top module: `chipset_cfg_regs`

## Requirements
- R1: A write to port 0x22 stores a register number. A later read or write at port 0x23 reaches the register with that number.
- R2: Writes at port 0x23 change state only for register numbers 0x41, 0x44, 0x46, 0x48, 0x49, 0x4A, 0x4B, 0x4C, 0x4D, 0x4E and 0x4F. A data-port write to any other number leaves every readback and the exported bus unchanged.
- R3: Register 0x46 stores only bit 6 of a written byte. All other bits of it stay zero.
- R4: After reset the data port reads 0x00 at 0x01, 0x0A at 0x40, 0x02 at 0x41, 0x80 at 0x44, 0x00 at 0x46, 0xC0 at 0x48, and 0x00 at 0x49 to 0x4C, 0x4E and 0x4F. Register 0x4D and every unlisted number hold 0xFF.
- R5: A read of register 0x45 returns 0x37 with bit 6 replaced by the keyboard-controller A20 input.
- R6: A read of register 0x4D returns its stored value ANDed with 0x8F. Bit 4 is then set when the wait-state count is 2 and clear when it is 1.
- R7: A write to register 0x4D selects 1 wait state when written bits 6:4 are all zero, and 2 otherwise. `waitTwo` reports the selection one clock after the write. It resets to 2 wait states by default.
- R8: Port 0x92 stores the written byte and reads it back. Its bit 1 drives `a20Gate` from the clock after the write.
- R9: A write to port 0x92 that sets bit 0 while the stored bit 0 is 0 raises `cpuResetPulse` for exactly one clock. A write that leaves bit 0 at 1 raises no pulse.
- R10: A read at any port other than 0x23 and 0x92, and any read while the read strobe is low, returns 0xFF.
- R11: Reset clears the register number to 0x00 and port 0x92 to 0x00.
- R12: `cfgRegs` carries the stored writable registers as bytes. Byte 0 (bits 7:0) holds 0x41, then in order 0x44, 0x46, 0x48, 0x49, 0x4A, 0x4B, 0x4C, 0x4D, 0x4E, and byte 10 holds 0x4F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 8 | I/O port address |
| ioWr | input | 1 | Write strobe, one clock per write |
| ioRd | input | 1 | Read strobe |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Read data, 0xFF when nothing matches |
| kbcA20 | input | 1 | A20 state from the keyboard controller |
| cfgRegs | output | 88 | Stored writable registers, one byte per register |
| waitTwo | output | 1 | 1 selects two CPU wait states, 0 selects one |
| a20Gate | output | 1 | Fast A20 gate from port 0x92 bit 1 |
| cpuResetPulse | output | 1 | One-clock soft reset request |

## Verification
A bad register number, a missing write mask or a wrong whitelist slot appears on `ioRdData` at the very next data-port read. It also appears on the matching byte of `cfgRegs` one clock after the offending write. A wait-state, A20 or soft-reset edge fault shows on `waitTwo`, `a20Gate` or `cpuResetPulse` in the clock after the write, so every check samples one clock after the write is applied. A pulse that is too wide, or that repeats, shows in the following clock.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_SLOTS = 11;
  localparam int REG_BUS_W = BYTE_W * NUM_SLOTS;

  // writable register numbers; slot order defines the export bus layout
  localparam logic [BYTE_W-1:0] SLOT_IDX [NUM_SLOTS] = '{
    8'h41, 8'h44, 8'h46, 8'h48, 8'h49, 8'h4A, 8'h4B, 8'h4C, 8'h4D, 8'h4E, 8'h4F};
  localparam logic [BYTE_W-1:0] SLOT_RST [NUM_SLOTS] = '{
    8'h02, 8'h80, 8'h00, 8'hC0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00};
  localparam logic [BYTE_W-1:0] SLOT_MASK [NUM_SLOTS] = '{
    8'hFF, 8'hFF, 8'h40, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
  localparam int SLOT_PM = 2;
  localparam int SLOT_WAIT = 8;

  // read-only register numbers and their constant contents
  localparam logic [BYTE_W-1:0] RO_IDX_A = 8'h01;
  localparam logic [BYTE_W-1:0] RO_VAL_A = 8'h00;
  localparam logic [BYTE_W-1:0] RO_IDX_B = 8'h40;
  localparam logic [BYTE_W-1:0] RO_VAL_B = 8'h0A;
  localparam logic [BYTE_W-1:0] STATUS_IDX = 8'h45;
  localparam logic [BYTE_W-1:0] STATUS_VAL = 8'h37;
  localparam logic [BYTE_W-1:0] WAIT_RD_MASK = 8'h8F;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

  typedef struct packed {
    logic idxWr;
    logic dataWr;
    logic sysWr;
    logic dataRd;
    logic sysRd;
  } ioStrobes_t;
endpackage

// File: rtl/cfg_ctl.sv
module cfg_ctl
  import cfg_pkg::*;
#(
  parameter logic [7:0] IDX_PORT = 8'h22,
  parameter logic [7:0] DATA_PORT = 8'h23,
  parameter logic [7:0] SYS_PORT = 8'h92
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] ioAddr,
  input  logic       ioWr,
  input  logic       ioRd,
  output ioStrobes_t strb
);
  logic hitIdx, hitData, hitSys;

  assign hitIdx  = (ioAddr == IDX_PORT);
  assign hitData = (ioAddr == DATA_PORT);
  assign hitSys  = (ioAddr == SYS_PORT);

  always_comb begin
    strb = '0;
    strb.idxWr  = ioWr & hitIdx;
    strb.dataWr = ioWr & hitData;
    strb.sysWr  = ioWr & hitSys;
    strb.dataRd = ioRd & hitData;
    strb.sysRd  = ioRd & hitSys;
  end

  AST_WR_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.idxWr, strb.dataWr, strb.sysWr})) else $error("write strobes overlap"); // R1
  AST_RD_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataRd || strb.sysRd) |-> ioRd) else $error("read strobe without ioRd"); // R10
endmodule

// File: rtl/cfg_dp.sv
module cfg_dp
  import cfg_pkg::*;
#(
  parameter bit RST_WAIT_TWO = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ioStrobes_t           strb,
  input  logic [BYTE_W-1:0]    wrData,
  input  logic                 kbcA20,
  output logic [BYTE_W-1:0]    rdData,
  output logic [REG_BUS_W-1:0] cfgRegs,
  output logic                 waitTwo,
  output logic                 a20Gate,
  output logic                 cpuResetPulse
);
  logic [BYTE_W-1:0] idxReg;
  logic [BYTE_W-1:0] sysReg;
  logic [BYTE_W-1:0] slotReg [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotHit;
  logic waitReg, pulseReg;

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) slotHit[s] = (idxReg == SLOT_IDX[s]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg <= '0;
      sysReg <= '0;
      waitReg <= RST_WAIT_TWO;
      pulseReg <= 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) slotReg[s] <= SLOT_RST[s];
    end else begin
      if (strb.idxWr) idxReg <= wrData;
      if (strb.dataWr) begin
        for (int s = 0; s < NUM_SLOTS; s++)
          if (slotHit[s]) slotReg[s] <= wrData & SLOT_MASK[s];
        if (slotHit[SLOT_WAIT]) waitReg <= |wrData[6:4];
      end
      pulseReg <= strb.sysWr & wrData[0] & ~sysReg[0];
      if (strb.sysWr) sysReg <= wrData;
    end
  end

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_export
      assign cfgRegs[g*BYTE_W +: BYTE_W] = slotReg[g];
    end
  endgenerate

  always_comb begin
    rdData = IDLE_BYTE;
    if (strb.sysRd) begin
      rdData = sysReg;
    end else if (strb.dataRd) begin
      if (idxReg == RO_IDX_A) rdData = RO_VAL_A;
      else if (idxReg == RO_IDX_B) rdData = RO_VAL_B;
      else if (idxReg == STATUS_IDX) rdData = {STATUS_VAL[7], kbcA20, STATUS_VAL[5:0]};
      else begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
          if (slotHit[s]) begin
            if (s == SLOT_WAIT)
              rdData = (slotReg[s] & WAIT_RD_MASK) | {3'b000, waitReg, 4'b0000};
            else
              rdData = slotReg[s];
          end
        end
      end
    end
  end

  assign waitTwo = waitReg;
  assign a20Gate = sysReg[1];
  assign cpuResetPulse = pulseReg;

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    cpuResetPulse |=> !cpuResetPulse) else $error("reset pulse too wide"); // R9
  AST_PULSE_FROM_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuResetPulse) |-> (sysReg[0] && $past(strb.sysWr))) else $error("pulse without edge write"); // R9
  AST_PM_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (slotReg[SLOT_PM] & ~SLOT_MASK[SLOT_PM]) == '0) else $error("masked bits set"); // R3
  AST_UNLISTED_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && slotHit == '0) |=> $stable(cfgRegs)) else $error("unlisted write changed state"); // R2
  AST_A20_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.sysWr |=> (a20Gate == $past(wrData[1]))) else $error("a20 mismatch"); // R8
  AST_WAIT_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && slotHit[SLOT_WAIT]) |=> (waitTwo == |$past(wrData[6:4]))) else $error("wait mismatch"); // R7
endmodule

// File: rtl/chipset_cfg_regs.sv
module chipset_cfg_regs
  import cfg_pkg::*;
#(
  parameter logic [7:0] IDX_PORT = 8'h22,
  parameter logic [7:0] DATA_PORT = 8'h23,
  parameter logic [7:0] SYS_PORT = 8'h92,
  parameter bit RST_WAIT_TWO = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           ioAddr,
  input  logic                 ioWr,
  input  logic                 ioRd,
  input  logic [7:0]           ioWrData,
  output logic [7:0]           ioRdData,
  input  logic                 kbcA20,
  output logic [REG_BUS_W-1:0] cfgRegs,
  output logic                 waitTwo,
  output logic                 a20Gate,
  output logic                 cpuResetPulse
);
  ioStrobes_t strb;

  cfg_ctl #(.IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT), .SYS_PORT(SYS_PORT)) u_ctl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd), .strb(strb)
  );

  cfg_dp #(.RST_WAIT_TWO(RST_WAIT_TWO)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(ioWrData), .kbcA20(kbcA20),
    .rdData(ioRdData), .cfgRegs(cfgRegs), .waitTwo(waitTwo), .a20Gate(a20Gate),
    .cpuResetPulse(cpuResetPulse)
  );
endmodule

// File: tb/chipset_cfg_regs_tb.sv
`timescale 1ns/1ps
module chipset_cfg_regs_tb;
  localparam int BUS_W = 88;
  localparam int NV = 31;
  // {reqNum[3:0], isRead, port, wrData, expected}
  localparam logic [28:0] VEC [NV] = '{
    {4'd0, 1'b0, 8'h22, 8'h41, 8'h00},
    {4'd4, 1'b1, 8'h23, 8'h00, 8'h02},  // R4
    {4'd0, 1'b0, 8'h22, 8'h01, 8'h00},
    {4'd4, 1'b1, 8'h23, 8'h00, 8'h00},  // R4
    {4'd0, 1'b0, 8'h23, 8'h55, 8'h00},
    {4'd2, 1'b1, 8'h23, 8'h00, 8'h00},  // R2 read-only number ignores write
    {4'd0, 1'b0, 8'h22, 8'h40, 8'h00},
    {4'd4, 1'b1, 8'h23, 8'h00, 8'h0A},  // R4
    {4'd0, 1'b0, 8'h22, 8'h45, 8'h00},
    {4'd5, 1'b1, 8'h23, 8'h00, 8'h37},  // R5 input low
    {4'd0, 1'b0, 8'h22, 8'h4D, 8'h00},
    {4'd6, 1'b1, 8'h23, 8'h00, 8'h9F},  // R6 reset value
    {4'd0, 1'b0, 8'h23, 8'h00, 8'h00},
    {4'd7, 1'b1, 8'h23, 8'h00, 8'h00},  // R7 one wait state
    {4'd0, 1'b0, 8'h23, 8'hF5, 8'h00},
    {4'd6, 1'b1, 8'h23, 8'h00, 8'h95},  // R6 mask plus wait bit
    {4'd0, 1'b0, 8'h22, 8'h46, 8'h00},
    {4'd0, 1'b0, 8'h23, 8'hFF, 8'h00},
    {4'd3, 1'b1, 8'h23, 8'h00, 8'h40},  // R3
    {4'd0, 1'b0, 8'h23, 8'hBF, 8'h00},
    {4'd3, 1'b1, 8'h23, 8'h00, 8'h00},  // R3
    {4'd0, 1'b0, 8'h22, 8'h4A, 8'h00},
    {4'd0, 1'b0, 8'h23, 8'hA5, 8'h00},
    {4'd1, 1'b1, 8'h23, 8'h00, 8'hA5},  // R1
    {4'd0, 1'b0, 8'h22, 8'h50, 8'h00},
    {4'd0, 1'b0, 8'h23, 8'h12, 8'h00},
    {4'd2, 1'b1, 8'h23, 8'h00, 8'hFF},  // R2
    {4'd10, 1'b1, 8'h30, 8'h00, 8'hFF}, // R10
    {4'd0, 1'b0, 8'h92, 8'h02, 8'h00},
    {4'd8, 1'b1, 8'h92, 8'h00, 8'h02},  // R8
    {4'd10, 1'b1, 8'h22, 8'h00, 8'hFF}  // R10
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] ioAddr = '0;
  logic ioWr = 1'b0;
  logic ioRd = 1'b0;
  logic [7:0] ioWrData = '0;
  logic [7:0] ioRdData;
  logic kbcA20 = 1'b0;
  logic [BUS_W-1:0] cfgRegs;
  logic waitTwo, a20Gate, cpuResetPulse;
  int nRun = 0;
  int nFail = 0;
  logic [BUS_W-1:0] snapRegs;

  always #2.5 clk = ~clk;

  chipset_cfg_regs u_dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .kbcA20(kbcA20), .cfgRegs(cfgRegs),
    .waitTwo(waitTwo), .a20Gate(a20Gate), .cpuResetPulse(cpuResetPulse)
  );

  task automatic check(input string req, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on a falling edge; the write lands at the next rising edge; returns on the falling edge after it
  task automatic ioWrite(input logic [7:0] port, input logic [7:0] data);
    @(negedge clk);
    ioAddr = port; ioWrData = data; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic ioRead(input logic [7:0] port, output logic [7:0] data);
    @(negedge clk);
    ioAddr = port; ioRd = 1'b1;
    #1 data = ioRdData;
    ioRd = 1'b0;
  endtask

  initial begin
    #1000000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check("R12", cfgRegs, 88'h0000FF00000000C0008002);
    check("R7", {87'd0, waitTwo}, 1);
    check("R8", {87'd0, a20Gate}, 0);
    check("R9", {87'd0, cpuResetPulse}, 0);
    ioRead(8'h92, rd); check("R11", {80'd0, rd}, 88'h00);
    ioRead(8'h23, rd); check("R11", {80'd0, rd}, 88'hFF);
    #1; check("R10", {80'd0, ioRdData}, 88'hFF);  // strobe low

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        ioRead(VEC[i][23:16], rd);
        check($sformatf("R%0d", VEC[i][28:25]), {80'd0, rd}, {80'd0, VEC[i][7:0]});
      end else begin
        ioWrite(VEC[i][23:16], VEC[i][15:8]);
      end
    end

    // exports after the table
    check("R12", {80'd0, cfgRegs[47:40]}, 88'hA5);
    check("R3", {80'd0, cfgRegs[23:16]}, 88'h00);
    check("R7", {87'd0, waitTwo}, 1);
    check("R8", {87'd0, a20Gate}, 1);

    // unlisted write leaves the export bus unchanged (index is 0x50)
    snapRegs = cfgRegs;
    ioWrite(8'h23, 8'h77);
    check("R2", cfgRegs, snapRegs);

    // live status bit
    kbcA20 = 1'b1;
    ioWrite(8'h22, 8'h45);
    ioRead(8'h23, rd); check("R5", {80'd0, rd}, 88'h77);
    kbcA20 = 1'b0;

    // wait selection corners
    ioWrite(8'h22, 8'h4D);
    ioWrite(8'h23, 8'h10);
    check("R7", {87'd0, waitTwo}, 1);
    ioWrite(8'h23, 8'h80);
    check("R7", {87'd0, waitTwo}, 0);
    ioRead(8'h23, rd); check("R6", {80'd0, rd}, 88'h80);
    check("R12", {80'd0, cfgRegs[71:64]}, 88'h80);

    // soft reset edge detection (stored bit 0 is 0, A20 bit set)
    ioWrite(8'h92, 8'h03);
    check("R9", {87'd0, cpuResetPulse}, 1);
    @(negedge clk);
    check("R9", {87'd0, cpuResetPulse}, 0);
    ioWrite(8'h92, 8'h03);
    check("R9", {87'd0, cpuResetPulse}, 0);
    ioWrite(8'h92, 8'h00);
    check("R9", {87'd0, cpuResetPulse}, 0);
    check("R8", {87'd0, a20Gate}, 0);
    ioWrite(8'h92, 8'h01);
    check("R9", {87'd0, cpuResetPulse}, 1);
    check("R8", {87'd0, a20Gate}, 0);
    ioRead(8'h92, rd); check("R8", {80'd0, rd}, 88'h01);

    // index survives a read-back and still selects its register
    ioWrite(8'h22, 8'h48);
    ioRead(8'h23, rd); check("R1", {80'd0, rd}, 88'hC0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule